// File: doc/BRIEF.md
# Path BIP-8 Error Counter

This block watches a descrambled path frame arriving one byte per valid cycle and keeps an even bit-interleaved parity over it, eight parity lanes wide. Each frame carries, at a position flagged by the framer, a parity byte that covers the previous frame. The block compares that byte with its own result and adds the mismatches to a running error counter.

The running counter counts either every differing bit or at most one error per frame, depending on a mode input. A performance-interval strobe copies the running count into a held 16-bit output and restarts the count. A second mode input decides whether the running count stops at its maximum or wraps. Frame alignment and descrambling take place upstream.

Top module: `path_bip_monitor`

## Requirements
- R1: While rstN is low, errCount and the running count are zero, and no parity from an earlier frame is held.
- R2: The parity of a frame is the XOR of every byte taken with byteValid high, from the byte marked by frameStart up to the next frameStart. The byte marked by parityPos is left out. Cycles with byteValid low are ignored, whatever their data and markers show. The parity byte never shares a cycle with frameStart.
- R3: The parity byte of frame N+1 is compared with the parity of frame N. The parity byte of the first frame after reset is not compared.
- R4: With blockMode = 0, each comparison adds the number of differing bits (0 to 8) to the running count.
- R5: With blockMode = 1, each comparison adds 1 if any bit differs and 0 otherwise.
- R6: In a cycle with pmStrobe high, errCount takes the running count as it stood before that cycle. The running count then restarts from the errors found in that same cycle.
- R7: With satMode = 1, the running count stops at 65535 and does not wrap.
- R8: With satMode = 0, the running count wraps modulo 65536.
- R9: errCount changes only in the cycle after a pmStrobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous reset, active low |
| byteValid | input | 1 | byteData holds a frame byte this cycle |
| byteData | input | 8 | Descrambled frame byte |
| frameStart | input | 1 | This byte is the first byte of a frame |
| parityPos | input | 1 | This byte is the parity byte covering the previous frame |
| pmStrobe | input | 1 | Performance-interval boundary: latch and restart the count |
| blockMode | input | 1 | 1 = count block errors, 0 = count bit errors |
| satMode | input | 1 | 1 = saturate at maximum, 0 = wrap |
| errCount | output | 16 | Error count latched at the last interval strobe |

## Verification
The interval latch and a parity comparison can fall in the same cycle. The bench provokes this by raising pmStrobe on the very byte that carries a corrupted parity byte. It expects the latched value to hold only the errors counted before that cycle. The errors from that byte must then appear at the following strobe. A scoreboard built from the requirements predicts both values, and a monitor checks each one in the cycle after its strobe.

// File: rtl/path_bip_pkg.sv
package path_bip_pkg;

  // Per-cycle commands from control to datapath
  typedef struct packed {
    logic frameOpen;   // valid first byte of a frame
    logic foldByte;    // valid byte that enters the parity
    logic checkByte;   // valid parity byte with a prior parity to compare against
    logic latchCount;  // interval boundary
  } bipStrobe_t;

endpackage

// File: rtl/path_bip_ctrl.sv
module path_bip_ctrl
  import path_bip_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       byteValid,
  input  logic       frameStart,
  input  logic       parityPos,
  input  logic       pmStrobe,
  output bipStrobe_t strb
);

  logic seenFrame;  // a frame start has been observed since reset
  logic havePrev;   // a completed frame's parity is held

  always_ff @(posedge clk) begin
    if (!rstN) begin
      seenFrame <= 1'b0;
      havePrev  <= 1'b0;
    end else if (byteValid && frameStart) begin
      havePrev  <= seenFrame;
      seenFrame <= 1'b1;
    end
  end

  always_comb begin
    strb.frameOpen  = byteValid & frameStart;
    strb.foldByte   = byteValid & ~parityPos;
    strb.checkByte  = byteValid & parityPos & havePrev;
    strb.latchCount = pmStrobe;
  end

endmodule

// File: rtl/path_bip_dp.sv
module path_bip_dp
  import path_bip_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  bipStrobe_t        strb,
  input  logic [DATA_W-1:0] byteData,
  input  logic              blockMode,
  input  logic              satMode,
  output logic [CNT_W-1:0]  runCount
);

  localparam int INC_W = $clog2(DATA_W + 1);

  logic [DATA_W-1:0] accParity;
  logic [DATA_W-1:0] prevParity;
  logic [DATA_W-1:0] foldVal;
  logic [DATA_W-1:0] mismatch;
  logic [INC_W-1:0]  popCnt;
  logic [INC_W-1:0]  incVal;
  logic [CNT_W:0]    sumWide;
  logic [CNT_W-1:0]  nextCount;

  assign foldVal  = strb.foldByte ? byteData : '0;
  assign mismatch = byteData ^ prevParity;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      accParity  <= '0;
      prevParity <= '0;
    end else if (strb.frameOpen) begin
      prevParity <= accParity;
      accParity  <= foldVal;
    end else begin
      accParity  <= accParity ^ foldVal;
    end
  end

  always_comb begin
    popCnt = '0;
    for (int i = 0; i < DATA_W; i++) begin
      popCnt = popCnt + INC_W'(mismatch[i]);
    end
  end

  always_comb begin
    if (!strb.checkByte)  incVal = '0;
    else if (blockMode)   incVal = INC_W'(|mismatch);
    else                  incVal = popCnt;
  end

  assign sumWide = {1'b0, runCount} + {{(CNT_W + 1 - INC_W){1'b0}}, incVal};

  always_comb begin
    if (strb.latchCount)          nextCount = {{(CNT_W - INC_W){1'b0}}, incVal};
    else if (sumWide[CNT_W] && satMode) nextCount = '1;
    else                          nextCount = sumWide[CNT_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rstN) runCount <= '0;
    else       runCount <= nextCount;
  end

endmodule

// File: rtl/path_bip_monitor.sv
module path_bip_monitor
  import path_bip_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              byteValid,
  input  logic [DATA_W-1:0] byteData,
  input  logic              frameStart,
  input  logic              parityPos,
  input  logic              pmStrobe,
  input  logic              blockMode,
  input  logic              satMode,
  output logic [CNT_W-1:0]  errCount
);

  bipStrobe_t       strb;
  logic [CNT_W-1:0] runCount;

  path_bip_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .byteValid  (byteValid),
    .frameStart (frameStart),
    .parityPos  (parityPos),
    .pmStrobe   (pmStrobe),
    .strb       (strb)
  );

  path_bip_dp #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .byteData  (byteData),
    .blockMode (blockMode),
    .satMode   (satMode),
    .runCount  (runCount)
  );

  always_ff @(posedge clk) begin
    if (!rstN)                errCount <= '0;
    else if (strb.latchCount) errCount <= runCount;
  end

endmodule

// File: rtl/path_bip_monitor_chk.sv
module path_bip_monitor_chk #(
  parameter int DATA_W = 8,
  parameter int CNT_W  = 16
) (
  input logic             clk,
  input logic             rstN,
  input logic             pmStrobe,
  input logic             blockMode,
  input logic             satMode,
  input logic [CNT_W-1:0] runCount,
  input logic [CNT_W-1:0] errCount
);

  a_r1_reset_zero: assert property (@(posedge clk)
    !rstN |=> (errCount == '0 && runCount == '0));

  a_r9_hold_between: assert property (@(posedge clk) disable iff (!rstN)
    !pmStrobe |=> $stable(errCount));

  a_r6_latch_value: assert property (@(posedge clk) disable iff (!rstN)
    pmStrobe |=> errCount == $past(runCount));

  a_r4_bit_step: assert property (@(posedge clk) disable iff (!rstN)
    (!pmStrobe && !satMode) |=> (CNT_W'(runCount - $past(runCount)) <= CNT_W'(DATA_W)));

  a_r5_block_step: assert property (@(posedge clk) disable iff (!rstN)
    (!pmStrobe && blockMode) |=> (CNT_W'(runCount - $past(runCount)) <= CNT_W'(1)));

  a_r7_saturate_hold: assert property (@(posedge clk) disable iff (!rstN)
    (satMode && !pmStrobe && runCount == '1) |=> runCount == '1);

endmodule

bind path_bip_monitor path_bip_monitor_chk #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .pmStrobe  (pmStrobe),
  .blockMode (blockMode),
  .satMode   (satMode),
  .runCount  (runCount),
  .errCount  (errCount)
);

// File: tb/tb_path_bip_monitor.sv
module tb_path_bip_monitor;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        byteValid = 1'b0;
  logic [7:0]  byteData = '0;
  logic        frameStart = 1'b0;
  logic        parityPos = 1'b0;
  logic        pmStrobe = 1'b0;
  logic        blockMode = 1'b0;
  logic        satMode = 1'b0;
  logic [15:0] errCount;

  always #5 clk = ~clk;

  path_bip_monitor dut (
    .clk(clk), .rstN(rstN), .byteValid(byteValid), .byteData(byteData),
    .frameStart(frameStart), .parityPos(parityPos), .pmStrobe(pmStrobe),
    .blockMode(blockMode), .satMode(satMode), .errCount(errCount)
  );

  typedef struct { logic [15:0] val; string tag; } expItem_t;
  expItem_t expQ[$];

  int    vectors = 0;
  int    fails = 0;
  string curTag = "R1";

  // Reference model built from the requirements
  logic [7:0] mAcc = '0;
  logic [7:0] mPrev = '0;
  bit         mSeen = 0;
  bit         mHave = 0;
  int         mRun = 0;

  task automatic drive(input logic v, input logic [7:0] d, input logic sof,
                       input logic par, input logic pm);
    int inc;
    int s;
    logic [7:0] fold;
    logic [7:0] mism;
    expItem_t it;
    @(negedge clk);
    byteValid = v; byteData = d; frameStart = sof; parityPos = par; pmStrobe = pm;
    inc  = 0;
    fold = (v && !par) ? d : 8'h00;
    if (v && par && mHave) begin
      mism = d ^ mPrev;
      inc  = blockMode ? int'(mism != 8'h00) : $countones(mism);
    end
    if (v && sof) begin
      mPrev = mAcc; mAcc = fold; mHave = mSeen; mSeen = 1;
    end else begin
      mAcc = mAcc ^ fold;
    end
    if (pm) begin
      it.val = mRun[15:0]; it.tag = curTag;
      expQ.push_back(it);
      mRun = inc;
    end else begin
      s = mRun + inc;
      if (s > 65535) s = satMode ? 65535 : s - 65536;
      mRun = s;
    end
  endtask

  // Frame: start byte, parity byte (previous parity XOR errMask), data byte, junk idle
  task automatic sendFrame(input logic [7:0] d0, input logic [7:0] d2,
                           input logic [7:0] errMask, input logic pmOnParity);
    drive(1'b1, d0, 1'b1, 1'b0, 1'b0);
    drive(1'b1, mPrev ^ errMask, 1'b0, 1'b1, pmOnParity);
    drive(1'b1, d2, 1'b0, 1'b0, 1'b0);
    drive(1'b0, d0 ^ 8'hA5, 1'b1, 1'b1, 1'b0);  // ignored: byteValid low
  endtask

  task automatic pmLatch();
    drive(1'b0, 8'h00, 1'b0, 1'b0, 1'b1);
    drive(1'b0, 8'h00, 1'b0, 1'b0, 1'b0);
  endtask

  // Monitor: scoreboard compare after each strobe, hold check otherwise (R9)
  logic        armed = 1'b0;
  logic [15:0] lastSeen = '0;
  always @(posedge clk) armed <= pmStrobe && rstN;

  always @(negedge clk) begin
    if (rstN) begin
      if (armed) begin
        expItem_t it;
        vectors++;
        if (expQ.size() == 0) begin
          fails++;
          $display("FAIL %s: unexpected latch, errCount=%0d expected none", curTag, errCount);
        end else begin
          it = expQ.pop_front();
          if (errCount !== it.val) begin
            fails++;
            $display("FAIL %s: errCount=%0d expected %0d", it.tag, errCount, it.val);
          end
        end
      end else begin
        vectors++;
        if (errCount !== lastSeen) begin
          fails++;
          $display("FAIL R9: errCount=%0d expected %0d (no strobe)", errCount, lastSeen);
        end
      end
      lastSeen = errCount;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run hung, cycles=150000 expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    vectors++;  // R1: reset state
    if (errCount !== 16'd0) begin
      fails++;
      $display("FAIL R1: errCount=%0d expected 0", errCount);
    end
    rstN = 1'b1;

    curTag = "R3";  // first frame: corrupted parity byte is not compared
    sendFrame(8'h5A, 8'h0F, 8'hFF, 1'b0);
    pmLatch();

    curTag = "R2";  // varied data, correct parity, junk idle cycles
    sendFrame(8'h12, 8'h34, 8'h00, 1'b0);
    sendFrame(8'hFE, 8'h01, 8'h00, 1'b0);
    sendFrame(8'h80, 8'h7F, 8'h00, 1'b0);
    sendFrame(8'hC3, 8'h3C, 8'h00, 1'b0);
    pmLatch();

    curTag = "R4";  // bit errors: 1 + 2 + 8 + 4
    sendFrame(8'h11, 8'h22, 8'h01, 1'b0);
    sendFrame(8'h33, 8'h44, 8'h81, 1'b0);
    sendFrame(8'h55, 8'h66, 8'hFF, 1'b0);
    sendFrame(8'h77, 8'h88, 8'h0F, 1'b0);
    pmLatch();

    curTag = "R5";  // block errors: 1 + 0 + 1
    blockMode = 1'b1;
    sendFrame(8'h99, 8'hAA, 8'hFF, 1'b0);
    sendFrame(8'hBB, 8'hCC, 8'h00, 1'b0);
    sendFrame(8'hDD, 8'hEE, 8'h10, 1'b0);
    pmLatch();
    blockMode = 1'b0;

    curTag = "R6";  // strobe on an errored parity byte
    sendFrame(8'h21, 8'h43, 8'h03, 1'b0);
    sendFrame(8'h65, 8'h87, 8'h07, 1'b1);
    pmLatch();

    curTag = "R7";
    satMode = 1'b1;
    for (int f = 0; f < 8200; f++) sendFrame(8'(f), 8'(f * 3), 8'hFF, 1'b0);
    pmLatch();

    curTag = "R8";
    satMode = 1'b0;
    for (int f = 0; f < 8200; f++) sendFrame(8'(f * 5), 8'(f), 8'hFF, 1'b0);
    pmLatch();

    repeat (3) @(negedge clk);
    vectors++;
    if (expQ.size() != 0) begin
      fails++;
      $display("FAIL R6: pending latches=%0d expected 0", expQ.size());
    end
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

endmodule